// File: doc/BRIEF.md
# Hamming Single-Error-Correcting Codec

This block pairs an encoder and a decoder for 8-bit data words protected by a Hamming code. The encoder turns each data byte into a 12-bit codeword. Four check bits sit at the power-of-two positions of that codeword, and the data bits fill the remaining positions. The decoder takes a codeword as read back from storage and recomputes each parity group. It forms a syndrome whose value is the position of a single flipped bit, inverts that bit, and returns the corrected byte with an error flag and the syndrome. A syndrome that points past the last codeword position cannot come from one flipped bit, so it is reported as uncorrectable.

The encoder and decoder are independent channels, and each has a one-cycle pipeline register. A channel samples its input on a clock edge where its valid strobe is high. Its result and a one-cycle output strobe appear after that edge. Between strobes the outputs hold their last values. The decoder keeps its outcome as a registered status with four states. CLEAN means the syndrome is zero. DATA_FIX means the syndrome names a data position. CHECK_FIX means the syndrome names a check position. UNCORR means the syndrome is above 12. Each accepted codeword moves the status directly to the state its syndrome selects; any state can go to any other. Reset returns the status to CLEAN.

Top module: `hsec_codec`

## Requirements
- R1: Codeword position p (1 to 12) is carried on enc_cw[p-1] and dec_cw[p-1]. Check bits occupy positions 1, 2, 4 and 8. Data bit enc_data[k-1] (d_k, k = 1 to 8) occupies positions 3, 5, 6, 7, 9, 10, 11, 12 in order of k.
- R2: The check bit at position 2^j makes even parity over every position whose index has bit j set, its own position included. Every codeword the encoder emits therefore has a zero syndrome.
- R3: Data 8'h4D (d1..d8 = 1,0,1,1,0,0,1,0) encodes to 12'h4E5, which is 101001110010 read from position 1 to 12.
- R4: Each channel gives its result one clock after a sampled valid, with its output strobe high for exactly that cycle. When valid is low, the channel's outputs keep their values.
- R5: dec_syndrome bit j is the parity over the covered positions of the received word. A clean codeword gives syndrome 0, dec_err 0, dec_uncorr 0, and the data unchanged.
- R6: When the syndrome is a data position, that bit is inverted and the original data is returned with dec_err 1 and dec_uncorr 0. Example: 12'h6E5 (position 10 flipped) decodes to 8'h4D with syndrome 10.
- R7: When the syndrome is a check position (1, 2, 4, 8), dec_data equals the received data bits, dec_err is 1 and dec_uncorr is 0.
- R8: When the syndrome is 13, 14 or 15, no bit is inverted. dec_data equals the received data bits, and dec_err and dec_uncorr are both 1.
- R9: While rst_n is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_valid | input | 1 | Encoder input strobe |
| enc_data | input | 8 | Data byte to encode |
| enc_out_valid | output | 1 | Encoder result strobe |
| enc_cw | output | 12 | Encoded codeword, bit p-1 = position p |
| dec_valid | input | 1 | Decoder input strobe |
| dec_cw | input | 12 | Received codeword, bit p-1 = position p |
| dec_out_valid | output | 1 | Decoder result strobe |
| dec_data | output | 8 | Corrected data byte |
| dec_syndrome | output | 4 | Syndrome, equal to the failing position |
| dec_err | output | 1 | Nonzero syndrome seen |
| dec_uncorr | output | 1 | Syndrome above 12, not corrected |

## Verification
Some properties are checked on every cycle. Every emitted codeword must have a zero syndrome. The reported syndrome must match the parity of the word sampled one cycle earlier. The flags and data must follow the status for clean, check-position and uncorrectable syndromes. The one-cycle strobe and the holding of outputs between strobes are also checked. Only the bench scenarios can show a few things: the exact encoded value of each byte, that the bit at every one of the twelve positions is put back, and the stated examples 8'h4D to 12'h4E5 and 12'h6E5 to 8'h4D.

// File: rtl/hsec_pkg.sv
package hsec_pkg;

    typedef enum logic [1:0] {
        DS_CLEAN     = 2'd0,
        DS_DATA_FIX  = 2'd1,
        DS_CHECK_FIX = 2'd2,
        DS_UNCORR    = 2'd3
    } dec_state_e;

    // smallest k with 2^k - 1 >= m + k
    function automatic int chk_bits(input int m);
        int res;
        bit found;
        res = 1;
        found = 1'b0;
        for (int k = 1; k < 31; k++) begin
            if (!found && (((1 << k) - 1) >= (m + k))) begin
                res = k;
                found = 1'b1;
            end
        end
        return res;
    endfunction

    // position (from 1) of data bit index k (from 0)
    function automatic int data_pos(input int k);
        int cnt;
        int res;
        bit found;
        cnt = 0;
        res = 0;
        found = 1'b0;
        for (int p = 1; p < 1024; p++) begin
            if (!found && ((p & (p - 1)) != 0)) begin
                if (cnt == k) begin
                    res = p;
                    found = 1'b1;
                end
                cnt++;
            end
        end
        return res;
    endfunction

endpackage

// File: rtl/hsec_encoder.sv
module hsec_encoder #(
    parameter  int DATA_W = 8,
    localparam int CHK_W  = hsec_pkg::chk_bits(DATA_W),
    localparam int CW_W   = DATA_W + CHK_W
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [CW_W-1:0]   cw_o
);

    logic [CW_W-1:0] placed;
    logic [CW_W-1:0] chk_vec;

    for (genvar k = 0; k < DATA_W; k++) begin : g_place
        localparam int DP = hsec_pkg::data_pos(k);
        assign placed[DP-1] = data_i[k];
    end

    for (genvar j = 0; j < CHK_W; j++) begin : g_hole
        assign placed[(1 << j) - 1] = 1'b0;
    end

    always_comb begin
        chk_vec = '0;
        for (int j = 0; j < CHK_W; j++) begin
            logic par;
            par = 1'b0;
            for (int p = 1; p <= CW_W; p++) begin
                if (p[j]) par = par ^ placed[p-1];
            end
            chk_vec[(1 << j) - 1] = par;
        end
    end

    assign cw_o = placed | chk_vec;

endmodule

// File: rtl/hsec_syndrome.sv
module hsec_syndrome #(
    parameter  int DATA_W = 8,
    localparam int CHK_W  = hsec_pkg::chk_bits(DATA_W),
    localparam int CW_W   = DATA_W + CHK_W
) (
    input  logic [CW_W-1:0]  cw_i,
    output logic [CHK_W-1:0] syn_o
);

    always_comb begin
        syn_o = '0;
        for (int j = 0; j < CHK_W; j++) begin
            for (int p = 1; p <= CW_W; p++) begin
                if (p[j]) syn_o[j] = syn_o[j] ^ cw_i[p-1];
            end
        end
    end

endmodule

// File: rtl/hsec_corrector.sv
module hsec_corrector #(
    parameter  int DATA_W = 8,
    localparam int CHK_W  = hsec_pkg::chk_bits(DATA_W),
    localparam int CW_W   = DATA_W + CHK_W
) (
    input  logic [CW_W-1:0]       cw_i,
    input  logic [CHK_W-1:0]      syn_i,
    output logic [DATA_W-1:0]     data_o,
    output hsec_pkg::dec_state_e  state_o
);
    import hsec_pkg::*;

    localparam logic [CHK_W-1:0] LAST_POS = CHK_W'(CW_W);

    logic            in_range;
    logic [CW_W-1:0] fixed;

    assign in_range = (syn_i != '0) && (syn_i <= LAST_POS);

    always_comb begin
        for (int p = 1; p <= CW_W; p++) begin
            fixed[p-1] = cw_i[p-1] ^ (in_range && (syn_i == CHK_W'(p)));
        end
    end

    for (genvar k = 0; k < DATA_W; k++) begin : g_pick
        localparam int DP = data_pos(k);
        assign data_o[k] = fixed[DP-1];
    end

    always_comb begin
        if (syn_i == '0)                 state_o = DS_CLEAN;
        else if (!in_range)              state_o = DS_UNCORR;
        else if ($countones(syn_i) == 1) state_o = DS_CHECK_FIX;
        else                             state_o = DS_DATA_FIX;
    end

endmodule

// File: rtl/hsec_codec.sv
module hsec_codec #(
    parameter  int DATA_W = 8,
    localparam int CHK_W  = hsec_pkg::chk_bits(DATA_W),
    localparam int CW_W   = DATA_W + CHK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enc_valid,
    input  logic [DATA_W-1:0] enc_data,
    output logic              enc_out_valid,
    output logic [CW_W-1:0]   enc_cw,
    input  logic              dec_valid,
    input  logic [CW_W-1:0]   dec_cw,
    output logic              dec_out_valid,
    output logic [DATA_W-1:0] dec_data,
    output logic [CHK_W-1:0]  dec_syndrome,
    output logic              dec_err,
    output logic              dec_uncorr
);
    import hsec_pkg::*;

    logic [CW_W-1:0]   enc_cw_d;
    logic [CHK_W-1:0]  syn_d;
    logic [DATA_W-1:0] data_d;
    dec_state_e        state_d;
    dec_state_e        state_q;

    hsec_encoder #(.DATA_W(DATA_W)) u_enc (
        .data_i (enc_data),
        .cw_o   (enc_cw_d)
    );

    hsec_syndrome #(.DATA_W(DATA_W)) u_syn (
        .cw_i  (dec_cw),
        .syn_o (syn_d)
    );

    hsec_corrector #(.DATA_W(DATA_W)) u_fix (
        .cw_i    (dec_cw),
        .syn_i   (syn_d),
        .data_o  (data_d),
        .state_o (state_d)
    );

    // decoder status register
    always_ff @(posedge clk) begin
        if (!rst_n)         state_q <= DS_CLEAN;
        else if (dec_valid) state_q <= state_d;
    end

    // data pipeline registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enc_out_valid <= 1'b0;
            enc_cw        <= '0;
            dec_out_valid <= 1'b0;
            dec_data      <= '0;
            dec_syndrome  <= '0;
        end else begin
            enc_out_valid <= enc_valid;
            dec_out_valid <= dec_valid;
            if (enc_valid) enc_cw <= enc_cw_d;
            if (dec_valid) begin
                dec_data     <= data_d;
                dec_syndrome <= syn_d;
            end
        end
    end

    // flags from status
    always_comb begin
        unique case (state_q)
            DS_CLEAN:     begin dec_err = 1'b0; dec_uncorr = 1'b0; end
            DS_DATA_FIX:  begin dec_err = 1'b1; dec_uncorr = 1'b0; end
            DS_CHECK_FIX: begin dec_err = 1'b1; dec_uncorr = 1'b0; end
            DS_UNCORR:    begin dec_err = 1'b1; dec_uncorr = 1'b1; end
            default:      begin dec_err = 1'b0; dec_uncorr = 1'b0; end
        endcase
    end

endmodule

// File: rtl/hsec_codec_chk.sv
module hsec_codec_chk #(
    parameter  int DATA_W = 8,
    localparam int CHK_W  = hsec_pkg::chk_bits(DATA_W),
    localparam int CW_W   = DATA_W + CHK_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enc_valid,
    input logic              enc_out_valid,
    input logic [CW_W-1:0]   enc_cw,
    input logic              dec_valid,
    input logic [CW_W-1:0]   dec_cw,
    input logic              dec_out_valid,
    input logic [DATA_W-1:0] dec_data,
    input logic [CHK_W-1:0]  dec_syndrome,
    input logic              dec_err,
    input logic              dec_uncorr
);

    localparam logic [CHK_W-1:0] TOP_POS = CHK_W'(CW_W);

    function automatic logic [CHK_W-1:0] parity_of(input logic [CW_W-1:0] w);
        logic [CHK_W-1:0] s;
        s = '0;
        for (int p = 1; p <= CW_W; p++) begin
            for (int j = 0; j < CHK_W; j++) begin
                if (((p >> j) & 1) == 1) s[j] = s[j] ^ w[p-1];
            end
        end
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] raw_data(input logic [CW_W-1:0] w);
        logic [DATA_W-1:0] d;
        int k;
        d = '0;
        k = 0;
        for (int p = 1; p <= CW_W; p++) begin
            if ((p & (p - 1)) != 0) begin
                d[k] = w[p-1];
                k++;
            end
        end
        return d;
    endfunction

    assert_enc_zero_syn_R2: assert property (@(posedge clk) disable iff (!rst_n)
        enc_out_valid |-> (parity_of(enc_cw) == '0));

    assert_enc_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        enc_valid |=> enc_out_valid);

    assert_dec_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> dec_out_valid);

    assert_dec_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |=> (!dec_out_valid && $stable(dec_data) && $stable(dec_syndrome)
                        && $stable(dec_err)));

    assert_enc_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !enc_valid |=> (!enc_out_valid && $stable(enc_cw)));

    assert_syn_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> (dec_syndrome == parity_of($past(dec_cw))));

    assert_clean_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_out_valid && dec_syndrome == '0) |->
        (!dec_err && !dec_uncorr && dec_data == raw_data($past(dec_cw))));

    assert_check_pos_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_out_valid && $countones(dec_syndrome) == 1) |->
        (dec_err && !dec_uncorr && dec_data == raw_data($past(dec_cw))));

    assert_uncorr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_out_valid && dec_syndrome > TOP_POS) |->
        (dec_err && dec_uncorr && dec_data == raw_data($past(dec_cw))));

    assert_uncorr_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dec_uncorr |-> (dec_syndrome > TOP_POS));

endmodule

bind hsec_codec hsec_codec_chk #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .enc_valid     (enc_valid),
    .enc_out_valid (enc_out_valid),
    .enc_cw        (enc_cw),
    .dec_valid     (dec_valid),
    .dec_cw        (dec_cw),
    .dec_out_valid (dec_out_valid),
    .dec_data      (dec_data),
    .dec_syndrome  (dec_syndrome),
    .dec_err       (dec_err),
    .dec_uncorr    (dec_uncorr)
);

// File: tb/sim_hsec_codec.sv
`timescale 1ns/1ps
module sim_hsec_codec;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enc_valid = 1'b0;
    logic [7:0]  enc_data = '0;
    logic        enc_out_valid;
    logic [11:0] enc_cw;
    logic        dec_valid = 1'b0;
    logic [11:0] dec_cw = '0;
    logic        dec_out_valid;
    logic [7:0]  dec_data;
    logic [3:0]  dec_syndrome;
    logic        dec_err;
    logic        dec_uncorr;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    hsec_codec u0 (
        .clk(clk), .rst_n(rst_n),
        .enc_valid(enc_valid), .enc_data(enc_data),
        .enc_out_valid(enc_out_valid), .enc_cw(enc_cw),
        .dec_valid(dec_valid), .dec_cw(dec_cw),
        .dec_out_valid(dec_out_valid), .dec_data(dec_data),
        .dec_syndrome(dec_syndrome), .dec_err(dec_err), .dec_uncorr(dec_uncorr)
    );

    // reference encoder from the parity equations
    function automatic logic [11:0] ref_enc(input logic [7:0] d);
        logic [11:0] w;
        w[2]  = d[0]; w[4]  = d[1]; w[5]  = d[2]; w[6]  = d[3];
        w[8]  = d[4]; w[9]  = d[5]; w[10] = d[6]; w[11] = d[7];
        w[0]  = d[0] ^ d[1] ^ d[3] ^ d[4] ^ d[6];
        w[1]  = d[0] ^ d[2] ^ d[3] ^ d[5] ^ d[6];
        w[3]  = d[1] ^ d[2] ^ d[3] ^ d[7];
        w[7]  = d[4] ^ d[5] ^ d[6] ^ d[7];
        return w;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_enc(input logic [7:0] d, input logic [11:0] exp, input string req);
        @(negedge clk);
        enc_valid = 1'b1;
        enc_data  = d;
        @(negedge clk);
        enc_valid = 1'b0;
        check(enc_out_valid == 1'b1, "R4", "enc strobe", 32'(enc_out_valid), 32'd1);
        check(enc_cw == exp, req, "enc codeword", 32'(enc_cw), 32'(exp));
    endtask

    task automatic do_dec(input logic [11:0] w, input logic [7:0] ed, input logic [3:0] es,
                          input logic ee, input logic eu, input string req);
        @(negedge clk);
        dec_valid = 1'b1;
        dec_cw    = w;
        @(negedge clk);
        dec_valid = 1'b0;
        check(dec_out_valid == 1'b1, "R4", "dec strobe", 32'(dec_out_valid), 32'd1);
        check(dec_data == ed, req, "dec data", 32'(dec_data), 32'(ed));
        check(dec_syndrome == es, req, "syndrome", 32'(dec_syndrome), 32'(es));
        check(dec_err == ee, req, "err flag", 32'(dec_err), 32'(ee));
        check(dec_uncorr == eu, req, "uncorr flag", 32'(dec_uncorr), 32'(eu));
    endtask

    task automatic t_reset_R9();
        @(negedge clk);
        check({enc_out_valid, enc_cw, dec_out_valid, dec_data, dec_syndrome,
               dec_err, dec_uncorr} == '0, "R9", "outputs in reset",
              32'({enc_cw, dec_data, dec_syndrome}), 32'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_example_R3();
        do_enc(8'h4D, 12'h4E5, "R3");
        check(enc_cw[0] == 1'b1 && enc_cw[7] == 1'b1 && enc_cw[1] == 1'b0 && enc_cw[3] == 1'b0,
              "R1", "check bits at 1,2,4,8", 32'(enc_cw), 32'h4E5);
    endtask

    task automatic t_sweep_R2();
        for (int v = 0; v < 256; v++) begin
            do_enc(8'(v), ref_enc(8'(v)), "R2");
            do_dec(ref_enc(8'(v)), 8'(v), 4'd0, 1'b0, 1'b0, "R5");
        end
    endtask

    task automatic t_single_R6();
        logic [7:0] pats [6] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h4D, 8'h81};
        do_dec(12'h6E5, 8'h4D, 4'd10, 1'b1, 1'b0, "R6");
        for (int i = 0; i < 6; i++) begin
            for (int p = 1; p <= 12; p++) begin
                logic [11:0] w;
                w = ref_enc(pats[i]) ^ (12'd1 << (p - 1));
                if (p == 1 || p == 2 || p == 4 || p == 8)
                    do_dec(w, pats[i], 4'(p), 1'b1, 1'b0, "R7");
                else
                    do_dec(w, pats[i], 4'(p), 1'b1, 1'b0, "R6");
            end
        end
    endtask

    task automatic t_uncorr_R8();
        // pos 8 plus d2 (pos5) -> 13, d3 (pos6) -> 14, d4 (pos7) -> 15
        logic [7:0] base;
        base = 8'h3C;
        do_dec(ref_enc(base) ^ 12'h090, base ^ 8'h02, 4'd13, 1'b1, 1'b1, "R8");
        do_dec(ref_enc(base) ^ 12'h0A0, base ^ 8'h04, 4'd14, 1'b1, 1'b1, "R8");
        do_dec(ref_enc(base) ^ 12'h0C0, base ^ 8'h08, 4'd15, 1'b1, 1'b1, "R8");
        do_dec(ref_enc(base), base, 4'd0, 1'b0, 1'b0, "R5");
    endtask

    task automatic t_hold_R4();
        do_dec(12'h6E5, 8'h4D, 4'd10, 1'b1, 1'b0, "R6");
        do_enc(8'h4D, 12'h4E5, "R3");
        @(negedge clk);
        dec_cw   = 12'h000;
        enc_data = 8'hFF;
        @(negedge clk);
        check(dec_out_valid == 1'b0, "R4", "dec strobe drops", 32'(dec_out_valid), 32'd0);
        check(enc_out_valid == 1'b0, "R4", "enc strobe drops", 32'(enc_out_valid), 32'd0);
        check(dec_data == 8'h4D && dec_syndrome == 4'd10 && dec_err == 1'b1, "R4",
              "dec outputs held", 32'({dec_data, dec_syndrome}), 32'h4DA);
        check(enc_cw == 12'h4E5, "R4", "enc output held", 32'(enc_cw), 32'h4E5);
    endtask

    initial begin
        #(4 * 200000);
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset_R9();
        t_example_R3();
        t_hold_R4();
        t_sweep_R2();
        t_single_R6();
        t_uncorr_R8();
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule